// File: doc/BRIEF.md
# Antenna Diversity Dwell Controller

This block runs a two-antenna diversity measurement for a radio receiver. When a measurement is started, it connects antenna A for one programmable dwell period and latches the signal-strength reading at the last cycle of that dwell. It then connects antenna B for a second dwell of the same length and latches that reading too. One cycle later it raises a single-cycle completion pulse. Each dwell lasts the programmed dwell count times a prescaled step. The step is 20 clocks, or 40 clocks when the step-mode input is high.

A single control byte holds an automatic-selection enable and the dwell count. With automatic selection on, the block leaves the antenna with the strictly stronger reading connected when the measurement ends, and keeps the earlier antenna on a tie. With automatic selection off, the dwells and readings still run so that a host can compare the readings. The block then restores the earlier antenna, and the host sets the final antenna with a select bit and a load strobe. A dwell count of zero turns switching off: a start then completes at once.

The controller has four states. ST_IDLE waits for a start. ST_DWELL_A holds antenna A and ST_DWELL_B holds antenna B. ST_DONE drives the completion pulse. Transitions:
- ST_IDLE goes to ST_DWELL_A on a start with a nonzero dwell.
- ST_IDLE goes to ST_DONE on a start with a zero dwell.
- ST_DWELL_A goes to ST_DWELL_B at the end of its dwell.
- ST_DWELL_B goes to ST_DONE at the end of its dwell.
- ST_DONE always goes to ST_IDLE.

Top module: `ant_div_ctrl`

## Requirements
- R1: After reset the control byte is 00h, ant_sel is 0 (antenna A), both captured readings are 0 and meas_done is 0.
- R2: A cycle with cfg_we high loads the control byte from cfg_wdata: bit 7 is the automatic-selection enable and bits 5:0 are the dwell count. Bit 6 is reserved and has no effect on behaviour.
- R3: Each dwell lasts dwell × 20 clock cycles when step_sel is 0 and dwell × 40 when it is 1. The dwell count, step mode and enable are taken when the start is accepted, so later writes do not change a running measurement.
- R4: During the first dwell ant_sel is 0, and during the second it is 1. rssi_a takes rssi_in as sampled at the last cycle of the first dwell, and rssi_b takes it at the last cycle of the second dwell.
- R5: meas_done is high for exactly one cycle: the cycle right after the second dwell ends. This is cycle 2N+1 counted from the clock edge that accepts the start, where N is the dwell length in cycles.
- R6: With the enable at 1, the antenna whose reading is strictly higher is left selected at the end (0 = A, 1 = B).
- R7: With the enable at 1 and equal readings, ant_sel returns to the value it had before the measurement.
- R8: With the enable at 0, both readings are still captured, and ant_sel returns to its pre-measurement value at the end.
- R9: In ST_IDLE with the enable at 0, sw_load copies sw_sel onto ant_sel at the next edge. sw_load has no effect when the enable is 1 or while a measurement runs.
- R10: A meas_start outside ST_IDLE is ignored and does not alter the running measurement's timing.
- R11: With a dwell count of 0, a start gives meas_done on the next cycle, with no change to ant_sel or the captured readings.
- R12: ant_sel never changes in the middle of a dwell. It changes only when a start is accepted, at a dwell end, or on an accepted sw_load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| step_sel | input | 1 | Step mode: 0 = 20 clocks, 1 = 40 clocks |
| meas_start | input | 1 | Measurement start pulse |
| rssi_in | input | RSSI_W | Received signal strength input |
| sw_sel | input | 1 | Host antenna choice |
| sw_load | input | 1 | Host antenna load strobe |
| ant_sel | output | 1 | Selected antenna (0 = A, 1 = B) |
| rssi_a | output | RSSI_W | Reading captured at end of antenna A dwell |
| rssi_b | output | RSSI_W | Reading captured at end of antenna B dwell |
| meas_done | output | 1 | One-cycle measurement completion pulse |

## Verification
The measurement is swept over dwell counts 1 to 3 and both step modes. It is also swept over both enable values, both starting antennas and four reading pairs: A stronger, B stronger, equal, and adjacent extremes. The sweep separates the timing paths from the decision paths, so a wrong dwell length shows up apart from a wrong comparison or a wrong tie rule. In every run the bench adds the following mid-measurement stimulus:
- a spurious start;
- a host load of the opposite antenna;
- a rewrite of the control byte and of the step mode.

A timing mismatch then shows that the settings were not held or that a stray input was not ignored. Separate cases cover the reset state, the zero-dwell shortcut and the host load in each mode.

// File: rtl/ant_div_pkg.sv
package ant_div_pkg;
    localparam int CFG_W   = 8;
    localparam int EN_POS  = 7;
    localparam int DWELL_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DWELL_A,
        ST_DWELL_B,
        ST_DONE
    } meas_state_e;

    typedef struct packed {
        logic               hw_en;
        logic [DWELL_W-1:0] dwell;
    } ctrl_t;
endpackage

// File: rtl/ant_div_prescale.sv
module ant_div_prescale #(
    parameter int STEP_LO = 20,
    parameter int STEP_HI = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic step_hi,
    output logic tick
);
    localparam int CW = $clog2(STEP_HI + 1);
    localparam logic [CW-1:0] LIM_LO = CW'(STEP_LO - 1);
    localparam logic [CW-1:0] LIM_HI = CW'(STEP_HI - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit = step_hi ? LIM_HI : LIM_LO;
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ant_div_dwell.sv
module ant_div_dwell #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt_q;

    assign last = run && tick && (cnt_q == limit - W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || last)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ant_div_ctrl.sv
module ant_div_ctrl
    import ant_div_pkg::*;
#(
    parameter int RSSI_W  = 8,
    parameter int STEP_LO = 20,
    parameter int STEP_HI = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              step_sel,
    input  logic              meas_start,
    input  logic [RSSI_W-1:0] rssi_in,
    input  logic              sw_sel,
    input  logic              sw_load,
    output logic              ant_sel,
    output logic [RSSI_W-1:0] rssi_a,
    output logic [RSSI_W-1:0] rssi_b,
    output logic              meas_done
);
    meas_state_e       state_q, state_d;
    ctrl_t             ctrl_q, snap_q;
    logic              snap_step_q;
    logic              ant_q, prior_q;
    logic [RSSI_W-1:0] rssi_a_q, rssi_b_q;
    logic              run, tick, dwell_end;

    assign run = (state_q == ST_DWELL_A) || (state_q == ST_DWELL_B);

    ant_div_prescale #(.STEP_LO(STEP_LO), .STEP_HI(STEP_HI)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .step_hi(snap_step_q),
        .tick   (tick)
    );

    ant_div_dwell #(.W(DWELL_W)) u_dwell (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick),
        .limit(snap_q.dwell),
        .last (dwell_end)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (meas_start)
                    state_d = (ctrl_q.dwell == '0) ? ST_DONE : ST_DWELL_A;
            end
            ST_DWELL_A: if (dwell_end) state_d = ST_DWELL_B;
            ST_DWELL_B: if (dwell_end) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
        endcase
    end

    // registered outputs and capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            snap_q      <= '0;
            snap_step_q <= 1'b0;
            ant_q       <= 1'b0;
            prior_q     <= 1'b0;
            rssi_a_q    <= '0;
            rssi_b_q    <= '0;
        end else begin
            if (cfg_we)
                ctrl_q <= '{hw_en: cfg_wdata[EN_POS], dwell: cfg_wdata[DWELL_W-1:0]};
            unique case (state_q)
                ST_IDLE: begin
                    if (meas_start) begin
                        snap_q      <= ctrl_q;
                        snap_step_q <= step_sel;
                        prior_q     <= ant_q;
                        if (ctrl_q.dwell != '0)
                            ant_q <= 1'b0;
                    end else if (sw_load && !ctrl_q.hw_en) begin
                        ant_q <= sw_sel;
                    end
                end
                ST_DWELL_A: begin
                    if (dwell_end) begin
                        rssi_a_q <= rssi_in;
                        ant_q    <= 1'b1;
                    end
                end
                ST_DWELL_B: begin
                    if (dwell_end) begin
                        rssi_b_q <= rssi_in;
                        if (!snap_q.hw_en)
                            ant_q <= prior_q;
                        else if (rssi_in > rssi_a_q)
                            ant_q <= 1'b1;
                        else if (rssi_a_q > rssi_in)
                            ant_q <= 1'b0;
                        else
                            ant_q <= prior_q;
                    end
                end
                ST_DONE: begin
                end
            endcase
        end
    end

    assign ant_sel   = ant_q;
    assign rssi_a    = rssi_a_q;
    assign rssi_b    = rssi_b_q;
    assign meas_done = (state_q == ST_DONE);
endmodule

// File: rtl/ant_div_chk.sv
module ant_div_chk
    import ant_div_pkg::*;
#(
    parameter int RSSI_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input meas_state_e       state_q,
    input logic              dwell_end,
    input logic              meas_start,
    input logic [DWELL_W-1:0] cfg_dwell,
    input logic              ant_sel,
    input logic [RSSI_W-1:0] rssi_a,
    input logic              meas_done
);
    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |=> !meas_done);

    // R12
    ant_hold_mid_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DWELL_A || state_q == ST_DWELL_B) && !dwell_end) |=> $stable(ant_sel));

    // R4
    rssi_a_capture_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DWELL_A) |=> $stable(rssi_a));

    // R10
    start_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DWELL_B && !dwell_end && meas_start) |=> (state_q == ST_DWELL_B));

    // R11
    zero_dwell_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && meas_start && cfg_dwell == '0) |=> meas_done);
endmodule

bind ant_div_ctrl ant_div_chk #(.RSSI_W(RSSI_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .dwell_end (dwell_end),
    .meas_start(meas_start),
    .cfg_dwell (ctrl_q.dwell),
    .ant_sel   (ant_sel),
    .rssi_a    (rssi_a),
    .meas_done (meas_done)
);

// File: tb/ant_div_ctrl_tb.sv
module ant_div_ctrl_tb;
    localparam int RW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic          step_sel = 1'b0;
    logic          meas_start = 1'b0;
    logic [RW-1:0] rssi_in = '0;
    logic          sw_sel = 1'b0;
    logic          sw_load = 1'b0;
    logic          ant_sel;
    logic [RW-1:0] rssi_a, rssi_b;
    logic          meas_done;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ant_div_ctrl #(.RSSI_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .step_sel(step_sel), .meas_start(meas_start), .rssi_in(rssi_in),
        .sw_sel(sw_sel), .sw_load(sw_load), .ant_sel(ant_sel),
        .rssi_a(rssi_a), .rssi_b(rssi_b), .meas_done(meas_done)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] b);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = b;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic host_load(input bit v);
        @(negedge clk); sw_sel = v; sw_load = 1'b1;
        @(negedge clk); sw_load = 1'b0;
    endtask

    task automatic run_meas(input int dw, input bit st, input bit en,
                            input int ra, input int rb, input bit prior, input bit rsv);
        int n, bad_a, bad_b, bad_done, exp_fin;
        logic [5:0] dwv;
        dwv = 6'(dw);
        write_cfg(8'h00);
        host_load(prior);
        write_cfg({en, rsv, dwv});
        step_sel = st;
        rssi_in  = RW'(ra);
        n = dw * (st ? 40 : 20);
        bad_a = 0; bad_b = 0; bad_done = 0;
        if (en) exp_fin = (ra > rb) ? 0 : (rb > ra) ? 1 : int'(prior);
        else    exp_fin = int'(prior);
        @(negedge clk); meas_start = 1'b1;
        for (int c = 1; c <= 2*n + 2; c++) begin
            @(negedge clk);
            if (c <= n) begin
                if (ant_sel !== 1'b0) bad_a++;
                if (meas_done !== 1'b0) bad_done++;
            end
            if (c > n && c <= 2*n) begin
                if (ant_sel !== 1'b1) bad_b++;
                if (meas_done !== 1'b0) bad_done++;
            end
            if (c == n + 1)
                check(rssi_a == RW'(ra), "R4 rssi_a capture", int'(rssi_a), ra);
            if (c == 2*n + 1) begin
                check(meas_done === 1'b1, "R5 done at 2N+1", int'(meas_done), 1);
                check(rssi_b == RW'(rb), en ? "R4 rssi_b capture" : "R8 rssi_b capture sw mode",
                      int'(rssi_b), rb);
                check(ant_sel === exp_fin[0],
                      !en ? "R8 sw mode final antenna" : (ra == rb) ? "R7 tie keeps prior"
                                                                    : "R6 stronger antenna",
                      int'(ant_sel), exp_fin);
            end
            if (c == 2*n + 2)
                check(meas_done === 1'b0, "R5 done single cycle", int'(meas_done), 0);
            // stray stimulus while busy: R10 start, R9 load, R3 config rewrite
            meas_start = (c == 2);
            sw_load    = (c == 1);
            sw_sel     = !prior;
            cfg_we     = (c == 3);
            cfg_wdata  = {!en, 1'b0, 6'd63};
            if (c == 3) step_sel = !st;
            if (c == n + 1) rssi_in = RW'(rb);
        end
        cfg_we = 1'b0;
        sw_load = 1'b0;
        meas_start = 1'b0;
        check(bad_a == 0, "R3 R12 antenna A for full dwell", bad_a, 0);
        check(bad_b == 0, "R3 R12 antenna B for full dwell", bad_b, 0);
        check(bad_done == 0, "R5 R10 no early done", bad_done, 0);
    endtask

    function automatic int pat_a(input int p);
        case (p) 0: return 50; 1: return 20; 2: return 33; default: return 254; endcase
    endfunction
    function automatic int pat_b(input int p);
        case (p) 0: return 20; 1: return 50; 2: return 33; default: return 255; endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ant_sel === 1'b0, "R1 reset ant_sel", int'(ant_sel), 0);
        check(rssi_a == '0 && rssi_b == '0, "R1 reset readings", int'(rssi_a) + int'(rssi_b), 0);
        check(meas_done === 1'b0, "R1 reset done", int'(meas_done), 0);
        // R1 reset control byte has dwell 0: start completes at once
        meas_start = 1'b1;
        @(negedge clk); meas_start = 1'b0;
        check(meas_done === 1'b1, "R1 reset control byte zero dwell", int'(meas_done), 1);
        @(negedge clk);

        // R9 host load in sw mode
        write_cfg(8'h02);
        host_load(1'b1);
        check(ant_sel === 1'b1, "R9 sw load to B", int'(ant_sel), 1);
        host_load(1'b0);
        check(ant_sel === 1'b0, "R9 sw load to A", int'(ant_sel), 0);
        // R9 host load ignored in hw mode
        write_cfg(8'h82);
        host_load(1'b1);
        check(ant_sel === 1'b0, "R9 sw load ignored hw mode", int'(ant_sel), 0);

        // R11 zero dwell: no switching, readings kept
        write_cfg(8'h00);
        host_load(1'b1);
        write_cfg(8'h80);
        rssi_in = 8'd99;
        @(negedge clk); meas_start = 1'b1;
        @(negedge clk); meas_start = 1'b0;
        check(meas_done === 1'b1, "R11 immediate done", int'(meas_done), 1);
        check(ant_sel === 1'b1, "R11 antenna unchanged", int'(ant_sel), 1);
        check(rssi_a == '0 && rssi_b == '0, "R11 readings unchanged", int'(rssi_a) + int'(rssi_b), 0);
        @(negedge clk);
        check(meas_done === 1'b0, "R11 done single cycle", int'(meas_done), 0);

        // sweep; R2 reserved bit toggled across runs
        for (int dw = 1; dw <= 3; dw++)
            for (int st = 0; st < 2; st++)
                for (int en = 0; en < 2; en++)
                    for (int p = 0; p < 4; p++)
                        for (int pr = 0; pr < 2; pr++)
                            run_meas(dw, st[0], en[0], pat_a(p), pat_b(p), pr[0], p[0] ^ pr[0]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule